// File: doc/BRIEF.md
# Condition Code Branch Evaluator

This block holds the processor's three condition flags (zero, sign and overflow) and decides whether a conditional register move or a conditional jump should take effect. The flags are stored in a small register. That register loads new values only on a clock edge where the set-flags strobe is high. The strobe is raised only by arithmetic and logical instructions.

The 4-bit function code of the instruction selects one of the conditions. The same table serves both the conditional move and the conditional jump. Code 0 means "always", which turns the instruction into a plain register move or an unconditional jump. The decision is combinational on the flags already stored. A flag update presented in a cycle therefore only influences decisions from the next cycle onward. The decision output is forced low whenever evaluation is not enabled.

Top module: `cc_branch_eval`

## Requirements
- R1: After reset the stored flags are zero=1, sign=0, overflow=0. With evaluation enabled, code 3 and code 5 then give true, and codes 2 and 6 give false.
- R2: While `eval_en` is low, `cond_true` is 0 for every function code and flag state.
- R3: Function code 0 gives `cond_true`=1 whenever `eval_en` is high, whatever the flags are.
- R4: Code 2 ("less") is true when sign XOR overflow is 1. Code 1 ("less or equal") is true when "less" holds or zero is 1.
- R5: Code 3 ("equal") is true when zero is 1. Code 4 ("not equal") is true when zero is 0.
- R6: Code 5 ("greater or equal") is the inverse of "less". Code 6 ("greater") is the inverse of "less or equal".
- R7: Function codes 7 to 15 always give `cond_true`=0.
- R8: The stored flags take `zf_in`, `sf_in` and `of_in` on a rising clock edge when `set_cc` is 1. When `set_cc` is 0 they hold their values, whatever the flag inputs carry.
- R9: The decision uses the flags stored before the current cycle. A `set_cc` load requested in a cycle does not change that cycle's `cond_true`; it changes it only after the next rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| fn_code | input | 4 | Condition selector from the instruction's function field |
| eval_en | input | 1 | High when a conditional move or jump is being evaluated |
| set_cc | input | 1 | Load strobe for the flag register |
| zf_in | input | 1 | New zero flag |
| sf_in | input | 1 | New sign flag |
| of_in | input | 1 | New overflow flag |
| cond_true | output | 1 | Condition holds and evaluation is enabled |

## Verification
`cond_true` is a combinational function of `fn_code`, `eval_en` and the stored flags. It is due in the same cycle as the inputs change. The bench therefore drives those inputs just after a falling edge and samples a few nanoseconds later, before the next rising edge. A flag load is due only after the rising edge on which `set_cc` is high. The bench checks the old decision before that edge and the new decision after it. Every flag combination is swept against all sixteen codes, with evaluation both enabled and disabled.

// File: rtl/cc_branch_eval.sv
module cc_branch_eval (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] fn_code,
  input  logic       eval_en,
  input  logic       set_cc,
  input  logic       zf_in,
  input  logic       sf_in,
  input  logic       of_in,
  output logic       cond_true
);

  logic zf_q, sf_q, of_q;
  logic lt, le, hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      zf_q <= 1'b1;
      sf_q <= 1'b0;
      of_q <= 1'b0;
    end else if (set_cc) begin
      zf_q <= zf_in;
      sf_q <= sf_in;
      of_q <= of_in;
    end
  end

  assign lt = sf_q ^ of_q;
  assign le = lt | zf_q;

  always_comb begin
    case (fn_code)
      4'd0:    hit = 1'b1;
      4'd1:    hit = le;
      4'd2:    hit = lt;
      4'd3:    hit = zf_q;
      4'd4:    hit = ~zf_q;
      4'd5:    hit = ~lt;
      4'd6:    hit = ~le;
      default: hit = 1'b0;
    endcase
  end

  assign cond_true = eval_en & hit;

  p_disabled_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !eval_en |-> !cond_true);

  p_always_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (eval_en && fn_code == 4'd0) |-> cond_true);

  p_unused_codes_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fn_code >= 4'd7) |-> !cond_true);

  p_eq_ne_split_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (eval_en && fn_code == 4'd3) |-> (cond_true == zf_q));

  p_hold_flags_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(set_cc) |-> $stable({zf_q, sf_q, of_q}));

  p_load_flags_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(set_cc)) |-> ({zf_q, sf_q, of_q} == $past({zf_in, sf_in, of_in})));

endmodule

// File: tb/cc_branch_eval_tb.sv
`timescale 1ns/1ps
module cc_branch_eval_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] fn_code = 4'd0;
  logic       eval_en = 1'b0;
  logic       set_cc = 1'b0;
  logic       zf_in = 1'b0;
  logic       sf_in = 1'b0;
  logic       of_in = 1'b0;
  logic       cond_true;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  cc_branch_eval u_dut (
    .clk(clk), .rst_n(rst_n), .fn_code(fn_code), .eval_en(eval_en),
    .set_cc(set_cc), .zf_in(zf_in), .sf_in(sf_in), .of_in(of_in),
    .cond_true(cond_true)
  );

  always #5 clk = ~clk;

  function automatic logic model(input logic [3:0] f, input logic en,
                                 input logic z, input logic s, input logic o);
    logic l, le, r;
    l  = s ^ o;
    le = l | z;
    case (f)
      4'd0: r = 1'b1;
      4'd1: r = le;
      4'd2: r = l;
      4'd3: r = z;
      4'd4: r = !z;
      4'd5: r = !l;
      4'd6: r = !le;
      default: r = 1'b0;
    endcase
    return en & r;
  endfunction

  task automatic check(input string req, input logic exp);
    checks++;
    if (cond_true !== exp) begin
      errors++;
      $display("FAIL %s: fn=%0d en=%0b actual=%0b expected=%0b",
               req, fn_code, eval_en, cond_true, exp);
    end
  endtask

  task automatic probe(input logic [3:0] f, input logic en);
    @(negedge clk);
    fn_code = f;
    eval_en = en;
    #2;
  endtask

  task automatic load(input logic z, input logic s, input logic o);
    @(negedge clk);
    zf_in = z; sf_in = s; of_in = o; set_cc = 1'b1;
    @(negedge clk);
    set_cc = 1'b0;
  endtask

  function automatic string req_of(input logic [3:0] f, input logic en);
    if (!en) return "R2";
    case (f)
      4'd0: return "R3";
      4'd1, 4'd2: return "R4";
      4'd3, 4'd4: return "R5";
      4'd5, 4'd6: return "R6";
      default: return "R7";
    endcase
  endfunction

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    probe(4'd3, 1'b1); check("R1", 1'b1);
    probe(4'd5, 1'b1); check("R1", 1'b1);
    probe(4'd2, 1'b1); check("R1", 1'b0);
    probe(4'd6, 1'b1); check("R1", 1'b0);

    for (int c = 0; c < 8; c++) begin
      load(c[2], c[1], c[0]);
      for (int f = 0; f < 16; f++) begin
        for (int e = 0; e < 2; e++) begin
          probe(f[3:0], e[0]);
          check(req_of(f[3:0], e[0]), model(f[3:0], e[0], c[2], c[1], c[0]));
        end
      end
    end

    // R8: inputs toggle with set_cc low, stored flags hold (z=0,s=1,o=0)
    load(1'b0, 1'b1, 1'b0);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      zf_in = 1'b1; sf_in = k[0]; of_in = ~k[0];
      probe(4'd3, 1'b1); check("R8", 1'b0);
      probe(4'd2, 1'b1); check("R8", 1'b1);
    end

    // R9: request a load, decision in that cycle uses the old flags
    @(negedge clk);
    zf_in = 1'b1; sf_in = 1'b0; of_in = 1'b0; set_cc = 1'b1;
    fn_code = 4'd3; eval_en = 1'b1;
    #2 check("R9", 1'b0);
    @(negedge clk);
    set_cc = 1'b0;
    #2 check("R9", 1'b1);
    probe(4'd2, 1'b1); check("R9", 1'b0);

    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule